// File: doc/BRIEF.md
# Addressed Frame Port Handler

This block sits behind a serial bus controller that has already turned the wire traffic into frames. For each frame the controller gives a header strobe carrying a 3-bit unit field and a 3-bit local address, then a stream of data bytes, then an end strobe. The handler keeps only frames whose unit field equals the strapped `unit_id`. It decodes the local address into a command-register write, a command-register read, or a write or read of port A, port B, or both ports together. Two 8-bit bidirectional ports are held as data and direction registers, and these registers drive the output-value and output-enable vectors.

One cycle after the end strobe the block reports a decision. `done_o` pulses and `ok_o` says whether the frame was accepted. For an accepted read, `rsp_n_o` gives the number of reply bytes and `rsp0_o`/`rsp1_o` carry them, taken from the live pin levels or from the command register. An accepted write updates the registers on the clock edge that ends the decision cycle. A rejected frame changes nothing. The `safe_i` input floats port A without touching port B.

The controller state machine has four states:
- `S_IDLE`: waiting for a frame.
- `S_RECV`: collecting bytes of an addressed frame.
- `S_SKIP`: waiting out a frame for another unit.
- `S_EXEC`: the one-cycle decision.

Its transitions are:
- header with matching unit: to `S_RECV`, from any state.
- header with another unit: to `S_SKIP`, from any state.
- end strobe in `S_RECV`: to `S_EXEC`.
- end strobe in `S_SKIP`: to `S_IDLE`.
- `S_EXEC`: to `S_IDLE` after one cycle.

Top module: `frame_port_handler`

## Requirements
- R1: A frame whose header unit field differs from `unit_id` yields no `done_o` pulse and changes no register.
- R2: A port-A write (local address 2) or port-B write (local address 6) is accepted with 1, 2 or 3 data bytes. The bytes are, in order, data, direction, option. Any other count is rejected and leaves every register unchanged.
- R3: An accepted one-byte port write loads the data register and sets all eight direction bits to output.
- R4: A write to both ports (local address 4) is accepted only with exactly 6 bytes, in the order A data, A direction, A option, B data, B direction, B option.
- R5: A write whose option byte (byte 3, and for the combined write also byte 6) is nonzero is rejected and changes nothing.
- R6: A command write (local address 0) is accepted only with exactly one byte, which becomes `cmd_o`. A command read (local address 1) returns that value as one byte.
- R7: Reads (odd local addresses) are accepted only with zero data bytes. Address 3 returns the port-A pin levels and address 7 returns the port-B pin levels, whatever the direction. Address 5 returns two bytes: A in `rsp0_o`, B in `rsp1_o`.
- R8: After reset both ports are high-impedance (`pa_oe`/`pb_oe` all zero), data registers are zero and `cmd_o` is zero.
- R9: A direction bit of 1 drives the matching pin from the data bit. While `safe_i` is high, `pa_oe` is all zero and port B keeps its programmed state.
- R10: `done_o` is high for exactly the cycle after the clock edge that samples `eof`. Register updates appear one cycle later.
- R11: A new header strobe before the end strobe discards the partial frame and starts a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| unit_id | input | 3 | strapped unit address |
| sof | input | 1 | frame header strobe |
| hdr_unit | input | 3 | unit field of the header |
| hdr_loc | input | 3 | local address; bit 0 = read |
| byte_vld | input | 1 | data byte valid |
| byte_dat | input | 8 | data byte |
| eof | input | 1 | end-of-frame strobe |
| safe_i | input | 1 | floats port A when high |
| pa_pin | input | 8 | sampled port-A pin levels |
| pb_pin | input | 8 | sampled port-B pin levels |
| done_o | output | 1 | decision pulse |
| ok_o | output | 1 | frame accepted |
| rsp_n_o | output | 2 | reply byte count |
| rsp0_o | output | 8 | first reply byte |
| rsp1_o | output | 8 | second reply byte |
| cmd_o | output | 8 | command register |
| pa_oe | output | 8 | port-A output enables |
| pa_out | output | 8 | port-A output values |
| pb_oe | output | 8 | port-B output enables |
| pb_out | output | 8 | port-B output values |

## Verification
The decision and reply bytes are due in the cycle after the edge that samples the end strobe. The port vectors change one cycle after that. The bench drives inputs on falling edges. At every falling edge it first compares all port vectors and `cmd_o` with its reference model, which holds the image as of the last rising edge. Only after that comparison, in the decision cycle, does it check `done_o`, `ok_o` and the reply, and then apply the accepted write to the model. As a result, a design that updates one cycle early or late mismatches on the very next compare.

// File: rtl/fph_pkg.sv
package fph_pkg;
    localparam int PORT_W    = 8;
    localparam int FRAME_MAX = 6;

    typedef enum logic [1:0] {S_IDLE, S_RECV, S_SKIP, S_EXEC} fph_state_t;

    typedef struct packed {
        logic              ok;
        logic              wr_cmd;
        logic              wr_a;
        logic              wr_b;
        logic [PORT_W-1:0] cmd;
        logic [PORT_W-1:0] a_data;
        logic [PORT_W-1:0] a_dir;
        logic [PORT_W-1:0] b_data;
        logic [PORT_W-1:0] b_dir;
        logic [1:0]        rsp_n;
        logic [PORT_W-1:0] rsp0;
        logic [PORT_W-1:0] rsp1;
    } fph_dec_t;
endpackage

// File: rtl/fph_ctrl.sv
module fph_ctrl
    import fph_pkg::*;
#(
    parameter int NB = FRAME_MAX,
    parameter int BW = PORT_W,
    localparam int CW = $clog2(NB + 2)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2:0]      unit_id,
    input  logic            sof,
    input  logic [2:0]      hdr_unit,
    input  logic [2:0]      hdr_loc,
    input  logic            byte_vld,
    input  logic [BW-1:0]   byte_dat,
    input  logic            eof,
    output logic            exec_o,
    output logic [2:0]      loc_o,
    output logic [CW-1:0]   cnt_o,
    output logic [NB*BW-1:0] bytes_o
);
    localparam logic [CW-1:0] CNT_SAT = CW'(NB + 1);

    fph_state_t      st_q, st_d;
    logic [2:0]      loc_q;
    logic [CW-1:0]   cnt_q;
    logic [NB*BW-1:0] buf_q;
    logic            hit;

    assign hit = (hdr_unit == unit_id);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE: if (sof) st_d = hit ? S_RECV : S_SKIP;
            S_RECV: if (sof) st_d = hit ? S_RECV : S_SKIP;
                    else if (eof) st_d = S_EXEC;
            S_SKIP: if (sof) st_d = hit ? S_RECV : S_SKIP;
                    else if (eof) st_d = S_IDLE;
            S_EXEC: if (sof) st_d = hit ? S_RECV : S_SKIP;
                    else st_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loc_q <= '0;
            cnt_q <= '0;
            buf_q <= '0;
        end else if (sof) begin
            loc_q <= hdr_loc;
            cnt_q <= '0;
            buf_q <= '0;
        end else if (st_q == S_RECV && byte_vld) begin
            for (int i = 0; i < NB; i++)
                if (cnt_q == CW'(i)) buf_q[i*BW +: BW] <= byte_dat;
            if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        exec_o  = (st_q == S_EXEC);
        loc_o   = loc_q;
        cnt_o   = cnt_q;
        bytes_o = buf_q;
    end

    // R10: the decision cycle follows the sampled end strobe
    p_exec_after_eof_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_EXEC) |-> $past(eof));
    // R10: the decision lasts exactly one cycle
    p_exec_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_EXEC) |=> (st_q != S_EXEC));
endmodule

// File: rtl/fph_decode.sv
module fph_decode
    import fph_pkg::*;
#(
    parameter int NB = FRAME_MAX,
    parameter int BW = PORT_W,
    localparam int CW = $clog2(NB + 2)
) (
    input  logic [2:0]       loc,
    input  logic [CW-1:0]    cnt,
    input  logic [NB*BW-1:0] bytes,
    input  logic [BW-1:0]    cmd_q,
    input  logic [BW-1:0]    pa_pin,
    input  logic [BW-1:0]    pb_pin,
    output fph_dec_t         dec
);
    logic [BW-1:0] b0, b1, b2, b3, b4, b5;
    logic one, two, three, six, none, single_ok;

    assign b0 = bytes[0*BW +: BW];
    assign b1 = bytes[1*BW +: BW];
    assign b2 = bytes[2*BW +: BW];
    assign b3 = bytes[3*BW +: BW];
    assign b4 = bytes[4*BW +: BW];
    assign b5 = bytes[5*BW +: BW];

    assign none  = (cnt == CW'(0));
    assign one   = (cnt == CW'(1));
    assign two   = (cnt == CW'(2));
    assign three = (cnt == CW'(3));
    assign six   = (cnt == CW'(6));
    assign single_ok = one | two | (three & (b2 == '0));

    always_comb begin
        dec        = '0;
        dec.cmd    = b0;
        dec.a_data = b0;
        dec.a_dir  = one ? '1 : b1;
        dec.b_data = b0;
        dec.b_dir  = one ? '1 : b1;
        unique case (loc)
            3'd0: begin dec.ok = one; dec.wr_cmd = 1'b1; end
            3'd2: begin dec.ok = single_ok; dec.wr_a = 1'b1; end
            3'd6: begin dec.ok = single_ok; dec.wr_b = 1'b1; end
            3'd4: begin
                dec.ok     = six & (b2 == '0) & (b5 == '0);
                dec.wr_a   = 1'b1;
                dec.wr_b   = 1'b1;
                dec.a_dir  = b1;
                dec.b_data = b3;
                dec.b_dir  = b4;
            end
            3'd1: begin dec.ok = none; dec.rsp_n = 2'd1; dec.rsp0 = cmd_q;  end
            3'd3: begin dec.ok = none; dec.rsp_n = 2'd1; dec.rsp0 = pa_pin; end
            3'd5: begin
                dec.ok = none; dec.rsp_n = 2'd2;
                dec.rsp0 = pa_pin; dec.rsp1 = pb_pin;
            end
            3'd7: begin dec.ok = none; dec.rsp_n = 2'd1; dec.rsp0 = pb_pin; end
        endcase
        if (!dec.ok) begin
            dec.rsp_n = 2'd0;
            dec.rsp0  = '0;
            dec.rsp1  = '0;
        end
    end
endmodule

// File: rtl/fph_port.sv
module fph_port #(
    parameter int W        = 8,
    parameter bit SAFE_HIZ = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] data_in,
    input  logic [W-1:0] dir_in,
    input  logic         safe,
    output logic [W-1:0] oe,
    output logic [W-1:0] out
);
    logic [W-1:0] data_q, dir_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            dir_q  <= '0;
        end else if (wr) begin
            data_q <= data_in;
            dir_q  <= dir_in;
        end
    end

    generate
        if (SAFE_HIZ) begin : g_safe
            assign oe = safe ? '0 : dir_q;
        end else begin : g_plain
            logic unused_safe;
            assign unused_safe = safe;
            assign oe = dir_q;
        end
    endgenerate

    assign out = data_q;
endmodule

// File: rtl/frame_port_handler.sv
module frame_port_handler
    import fph_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  unit_id,
    input  logic        sof,
    input  logic [2:0]  hdr_unit,
    input  logic [2:0]  hdr_loc,
    input  logic        byte_vld,
    input  logic [7:0]  byte_dat,
    input  logic        eof,
    input  logic        safe_i,
    input  logic [7:0]  pa_pin,
    input  logic [7:0]  pb_pin,
    output logic        done_o,
    output logic        ok_o,
    output logic [1:0]  rsp_n_o,
    output logic [7:0]  rsp0_o,
    output logic [7:0]  rsp1_o,
    output logic [7:0]  cmd_o,
    output logic [7:0]  pa_oe,
    output logic [7:0]  pa_out,
    output logic [7:0]  pb_oe,
    output logic [7:0]  pb_out
);
    localparam int NB = FRAME_MAX;
    localparam int W  = PORT_W;
    localparam int CW = $clog2(NB + 2);

    logic            exec;
    logic [2:0]      loc;
    logic [CW-1:0]   cnt;
    logic [NB*W-1:0] bytes;
    logic [W-1:0]    cmd_q;
    fph_dec_t        dec;
    logic [1:0]      port_wr;
    logic [1:0][W-1:0] p_data, p_dir, p_oe, p_out;

    fph_ctrl #(.NB(NB), .BW(W)) u_ctrl (
        .clk, .rst_n, .unit_id, .sof, .hdr_unit, .hdr_loc,
        .byte_vld, .byte_dat, .eof,
        .exec_o(exec), .loc_o(loc), .cnt_o(cnt), .bytes_o(bytes)
    );

    fph_decode #(.NB(NB), .BW(W)) u_dec (
        .loc, .cnt, .bytes, .cmd_q, .pa_pin, .pb_pin, .dec
    );

    always_ff @(posedge clk) begin
        if (!rst_n)                         cmd_q <= '0;
        else if (exec && dec.ok && dec.wr_cmd) cmd_q <= dec.cmd;
    end

    assign port_wr = {exec & dec.ok & dec.wr_b, exec & dec.ok & dec.wr_a};
    assign p_data  = {dec.b_data, dec.a_data};
    assign p_dir   = {dec.b_dir,  dec.a_dir};

    generate
        for (genvar g = 0; g < 2; g++) begin : g_port
            fph_port #(.W(W), .SAFE_HIZ(g == 0)) u_port (
                .clk, .rst_n, .wr(port_wr[g]),
                .data_in(p_data[g]), .dir_in(p_dir[g]), .safe(safe_i),
                .oe(p_oe[g]), .out(p_out[g])
            );
        end
    endgenerate

    always_comb begin
        done_o  = exec;
        ok_o    = exec & dec.ok;
        rsp_n_o = exec ? dec.rsp_n : 2'd0;
        rsp0_o  = exec ? dec.rsp0  : '0;
        rsp1_o  = exec ? dec.rsp1  : '0;
        cmd_o   = cmd_q;
        pa_oe   = p_oe[0];
        pa_out  = p_out[0];
        pb_oe   = p_oe[1];
        pb_out  = p_out[1];
    end

    // R2 / R5: a rejected frame leaves the register image as it was
    p_reject_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !ok_o) |=> ($stable(pa_out) && $stable(pb_out) &&
                               $stable(pb_oe) && $stable(cmd_o)));
    // R3: one-byte port-A write turns every A pin into an output
    p_single_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ok_o && loc == 3'd2 && cnt == CW'(1)) |=> (pa_oe == '1 || safe_i));
    // R4: combined write only with six bytes
    p_combo_six_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ok_o && loc == 3'd4) |-> (cnt == CW'(6)));
    // R7: accepted reads carry no data bytes
    p_read_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ok_o && loc[0]) |-> (cnt == CW'(0) && rsp_n_o != 2'd0));
    // R9: safety input floats port A
    p_safe_hiz_r9: assert property (@(posedge clk) disable iff (!rst_n)
        safe_i |-> (pa_oe == '0));
    // R10: reply lines are quiet outside the decision cycle
    p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> (!ok_o && rsp_n_o == 2'd0));
endmodule

// File: tb/tb_frame_port_handler.sv
`timescale 1ns/1ps
module tb_frame_port_handler;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] unit_id = 3'd5;
    logic sof = 0, byte_vld = 0, eof = 0, safe_i = 0;
    logic [2:0] hdr_unit = 0, hdr_loc = 0;
    logic [7:0] byte_dat = 0, ext_a = 8'hC3, ext_b = 8'h96;
    logic [7:0] pa_pin, pb_pin;
    logic done_o, ok_o;
    logic [1:0] rsp_n_o;
    logic [7:0] rsp0_o, rsp1_o, cmd_o, pa_oe, pa_out, pb_oe, pb_out;

    int compared = 0, mismatched = 0;
    logic [7:0] tx_q[$];
    logic [7:0] m_a_data = 0, m_a_dir = 0, m_b_data = 0, m_b_dir = 0, m_cmd = 0;

    always #2.5 clk = ~clk;

    assign pa_pin = (pa_oe & pa_out) | (~pa_oe & ext_a);
    assign pb_pin = (pb_oe & pb_out) | (~pb_oe & ext_b);

    frame_port_handler dut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_a_oe();
        return safe_i ? 8'h00 : m_a_dir;
    endfunction

    // every falling edge: port image against the model (R9 R8)
    task automatic tick();
        @(negedge clk);
        chk("R9 pa_oe", pa_oe, exp_a_oe());
        chk("R9 pa_out", pa_out, m_a_data);
        chk("R9 pb_oe", pb_oe, m_b_dir);
        chk("R9 pb_out", pb_out, m_b_data);
        chk("R6 cmd", cmd_o, m_cmd);
    endtask

    task automatic send(input logic [2:0] unit, input logic [2:0] loc, input string tag);
        int n;
        logic ok;
        logic [7:0] ea, eb;
        n = tx_q.size();
        tick(); sof = 1; hdr_unit = unit; hdr_loc = loc;
        foreach (tx_q[i]) begin
            tick(); sof = 0; byte_vld = 1; byte_dat = tx_q[i];
        end
        tick(); sof = 0; byte_vld = 0; eof = 1;
        tick(); eof = 0;
        // decision cycle (R10)
        if (unit != unit_id) begin
            chk({tag, " R1 done"}, done_o, 0);
            return;
        end
        chk({tag, " R10 done"}, done_o, 1);
        case (loc)
            3'd0: ok = (n == 1);
            3'd2, 3'd6: ok = (n >= 1 && n <= 3) && !(n == 3 && tx_q[2] != 0);
            3'd4: ok = (n == 6) && tx_q[2] == 0 && tx_q[5] == 0;
            default: ok = (n == 0);
        endcase
        chk({tag, " R2 ok"}, ok_o, ok);
        ea = (exp_a_oe() & m_a_data) | (~exp_a_oe() & ext_a);
        eb = (m_b_dir & m_b_data) | (~m_b_dir & ext_b);
        if (ok && loc[0]) begin
            case (loc)
                3'd1: begin chk({tag, " R6 n"}, rsp_n_o, 1); chk({tag, " R6 rsp"}, rsp0_o, m_cmd); end
                3'd3: begin chk({tag, " R7 n"}, rsp_n_o, 1); chk({tag, " R7 rspA"}, rsp0_o, ea); end
                3'd5: begin chk({tag, " R7 n"}, rsp_n_o, 2); chk({tag, " R7 rspA"}, rsp0_o, ea);
                             chk({tag, " R7 rspB"}, rsp1_o, eb); end
                default: begin chk({tag, " R7 n"}, rsp_n_o, 1); chk({tag, " R7 rspB"}, rsp0_o, eb); end
            endcase
        end else begin
            chk({tag, " R7 nrsp"}, rsp_n_o, 0);
        end
        if (ok) begin
            case (loc)
                3'd0: m_cmd = tx_q[0];
                3'd2: begin m_a_data = tx_q[0]; m_a_dir = (n == 1) ? 8'hFF : tx_q[1]; end
                3'd6: begin m_b_data = tx_q[0]; m_b_dir = (n == 1) ? 8'hFF : tx_q[1]; end
                3'd4: begin m_a_data = tx_q[0]; m_a_dir = tx_q[1];
                            m_b_data = tx_q[3]; m_b_dir = tx_q[4]; end
                default: ;
            endcase
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        tick();
        chk("R8 pa_oe reset", pa_oe, 0);
        chk("R8 pb_oe reset", pb_oe, 0);
        chk("R8 cmd reset", cmd_o, 0);
        // R3 one-byte write
        tx_q = '{8'h5A}; send(3'd5, 3'd2, "A1");
        tick(); chk("R3 all out", pa_oe, 8'hFF);
        // R2 two and three bytes, R5 option
        tx_q = '{8'h33, 8'h0F}; send(3'd5, 3'd2, "A2");
        tx_q = '{8'hAA, 8'hF0, 8'h00}; send(3'd5, 3'd2, "A3");
        tx_q = '{8'h11, 8'hFF, 8'h01}; send(3'd5, 3'd2, "R5 A3opt");
        tx_q = '{8'h11, 8'hFF, 8'h00, 8'h00}; send(3'd5, 3'd2, "R2 A4");
        tx_q.delete(); send(3'd5, 3'd2, "R2 A0");
        tx_q = '{8'h77}; send(3'd5, 3'd6, "B1");
        tx_q = '{8'h3C, 8'h81, 8'h00}; send(3'd5, 3'd6, "B3");
        // R4 combined
        tx_q = '{8'h12, 8'h0F, 8'h00, 8'h34, 8'hF0, 8'h00}; send(3'd5, 3'd4, "R4 AB6");
        tx_q = '{8'h99, 8'hFF, 8'h00, 8'h99, 8'hFF}; send(3'd5, 3'd4, "R4 AB5");
        tx_q = '{8'h99, 8'hFF, 8'h00, 8'h99, 8'hFF, 8'h80}; send(3'd5, 3'd4, "R5 ABopt");
        tx_q = '{8'h99, 8'hFF, 8'h00, 8'h99, 8'hFF, 8'h00, 8'h00}; send(3'd5, 3'd4, "R4 AB7");
        // R7 reads
        tx_q.delete(); send(3'd5, 3'd3, "R7 rdA");
        send(3'd5, 3'd5, "R7 rdAB");
        send(3'd5, 3'd7, "R7 rdB");
        tx_q = '{8'h00}; send(3'd5, 3'd3, "R7 rdA1");
        // R6 command
        tx_q = '{8'hA5}; send(3'd5, 3'd0, "R6 cmdw");
        tx_q = '{8'h01, 8'h02}; send(3'd5, 3'd0, "R6 cmdw2");
        tx_q.delete(); send(3'd5, 3'd1, "R6 cmdr");
        // R1 other unit
        tx_q = '{8'hEE}; send(3'd2, 3'd2, "R1 foreign");
        tick(); chk("R1 unchanged", pa_out, m_a_data);
        // R9 safety
        tx_q = '{8'h5A}; send(3'd5, 3'd2, "pre");
        safe_i = 1;
        tick(); chk("R9 safe A hiz", pa_oe, 0);
        chk("R9 safe B kept", pb_oe, m_b_dir);
        tx_q.delete(); send(3'd5, 3'd3, "R9 rdA safe");
        safe_i = 0;
        // R11 restart
        tick(); sof = 1; hdr_unit = 3'd5; hdr_loc = 3'd6;
        tick(); sof = 0; byte_vld = 1; byte_dat = 8'hDD;
        tick(); byte_vld = 0;
        tx_q = '{8'h42}; send(3'd5, 3'd2, "R11 restart");
        tick(); chk("R11 B kept", pb_out, m_b_data);
        repeat (3) tick();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule